// File: doc/BRIEF.md
# Four-Channel 14-Bit DAC Parallel Loader

This block is the digital front end of a four-channel 14-bit DAC that is driven from a parallel bus. A host writes a code into one channel's input register. The write can carry the whole 14-bit word at once, or it can arrive as two right-justified bytes: an 8-bit low part and a 6-bit high part. A byte-select line picks which part a byte write fills. A 3-bit channel address steers the write. Addresses above the channel count are dropped.

Each input register feeds a DAC latch, and the latch code is what the converter sees. A load strobe moves input registers into latches. In edge mode, a falling edge of the strobe loads all four latches on the same clock. In level mode, holding the strobe low makes every latch follow its own input register, so each channel updates as soon as its new data arrives. An asynchronous clear forces every latch to a parameterised clear code. The power-on reset sets that same code into both the latches and the input registers.

All strobes are sampled in the `clk_i` domain. A write is taken on the clock where the write strobe is first seen high after being low while chip select is low. The input register changes on that edge, and a latch changes no earlier than the following edge.

Top module: `dac_byte_loader`

## Requirements
- R1: After reset, every latch output equals CLR_CODE (default 14'h2000), and every input register also holds CLR_CODE, so a load straight after reset leaves the outputs at CLR_CODE.
- R2: A write is captured only on the clock where `wr_ni` is sampled high after being low, and only while `cs_ni` is low. With `cs_ni` high, no input register changes.
- R3: In byte mode (`word_mode_i`=0) with `byte_hi_i`=0, `data_i[7:0]` goes into bits 7:0 of the addressed input register, and bits 13:8 keep their value.
- R4: In byte mode with `byte_hi_i`=1, `data_i[5:0]` goes into bits 13:8 of the addressed input register. Bits 7:0 keep their value, and `data_i[13:6]` is ignored.
- R5: In word mode (`word_mode_i`=1), `data_i[13:0]` goes into the addressed input register in one write, and `byte_hi_i` has no effect.
- R6: Address values 0 to 3 select channels 0 to 3. A write to address 4 to 7 changes no input register.
- R7: In edge mode (`ldac_level_i`=0), the clock that first samples `ldac_ni` low after it was high loads all four latches from their input registers. While `ldac_ni` stays low, later writes do not reach the latches.
- R8: In level mode (`ldac_level_i`=1) with `ldac_ni` low, each latch takes its input register's value on the clock after that register changes.
- R9: A write alone never changes a latch output. Outputs change only through a load, a clear or reset.
- R10: Driving `clr_ni` low forces all latch outputs to CLR_CODE at once, without waiting for a clock, and leaves the input registers unchanged.
- R11: While `clr_ni` is low, loads have no effect and the outputs stay at CLR_CODE.
- R12: When a write and an edge-mode load happen on the same clock, the latch takes the input register's value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| cs_ni | input | 1 | Active-low chip select |
| wr_ni | input | 1 | Write strobe; a write is taken on its rising edge |
| byte_hi_i | input | 1 | Byte select: 0 = low 8 bits, 1 = high 6 bits |
| word_mode_i | input | 1 | 1 = full 14-bit write, 0 = byte write |
| addr_i | input | 3 | Channel address |
| data_i | input | 14 | Write data, right-justified in byte mode |
| ldac_ni | input | 1 | Active-low load strobe |
| ldac_level_i | input | 1 | 0 = edge-triggered load of all channels, 1 = level-held follow |
| clr_ni | input | 1 | Active-low asynchronous clear of the latches |
| dac_code_o | output | 56 | Latch codes, channel n in bits [14n+13:14n] |

## Verification
A write and a load can land on the same clock. The bench provokes this by raising the write strobe and dropping the load strobe in the same cycle. It then judges that the latch shows the value held before the write, and that a second load brings in the new word. A clear can also overlap a load. The bench pulses the load strobe while clear is held low and expects the clear code, then releases the clear. A later load must restore the input register values that were written before the clear.

// File: rtl/dac_ldr_pkg.sv
package dac_ldr_pkg;
  localparam int unsigned NUM_CH   = 4;
  localparam int unsigned CODE_W   = 14;
  localparam int unsigned LO_W     = 8;
  localparam int unsigned ADDR_W   = 3;
  localparam logic [CODE_W-1:0] CLR_DEFAULT = 14'h2000;
endpackage

// File: rtl/dac_wr_steer.sv
module dac_wr_steer #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CODE_W = 14,
  parameter int unsigned LO_W   = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic              byte_hi_i,
  input  logic              word_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CODE_W-1:0] data_i,
  output logic [NUM_CH-1:0] we_lo_o,
  output logic [NUM_CH-1:0] we_hi_o,
  output logic [CODE_W-1:0] wdata_o
);
  localparam int unsigned HI_W = CODE_W - LO_W;

  logic wr_q;
  logic wr_fire;
  logic sel_lo;
  logic sel_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b1;
    else         wr_q <= wr_ni;
  end

  assign wr_fire = wr_ni & ~wr_q & ~cs_ni;
  assign sel_lo  = word_mode_i | ~byte_hi_i;
  assign sel_hi  = word_mode_i | byte_hi_i;

  always_comb begin
    if (word_mode_i)    wdata_o = data_i;
    else if (byte_hi_i) wdata_o = {data_i[HI_W-1:0], {LO_W{1'b0}}};
    else                wdata_o = {{HI_W{1'b0}}, data_i[LO_W-1:0]};
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    logic hit;
    assign hit        = (addr_i == ADDR_W'(g));
    assign we_lo_o[g] = wr_fire & hit & sel_lo;
    assign we_hi_o[g] = wr_fire & hit & sel_hi;
  end

  // R6
  addr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_lo_o | we_hi_o));
  // R2
  cs_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> ((we_lo_o | we_hi_o) == '0));
endmodule

// File: rtl/dac_in_reg.sv
module dac_in_reg #(
  parameter int unsigned CODE_W = 14,
  parameter int unsigned LO_W   = 8,
  parameter logic [CODE_W-1:0] RST_CODE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_lo_i,
  input  logic              we_hi_i,
  input  logic [CODE_W-1:0] d_i,
  output logic [CODE_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= RST_CODE;
    end else begin
      if (we_lo_i) q_o[LO_W-1:0]      <= d_i[LO_W-1:0];
      if (we_hi_i) q_o[CODE_W-1:LO_W] <= d_i[CODE_W-1:LO_W];
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_lo_i && !we_hi_i) |=> $stable(q_o));
  // R3
  lo_keeps_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_lo_i && !we_hi_i) |=> q_o[CODE_W-1:LO_W] == $past(q_o[CODE_W-1:LO_W]));
  // R4
  hi_keeps_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_hi_i && !we_lo_i) |=> q_o[LO_W-1:0] == $past(q_o[LO_W-1:0]));
endmodule

// File: rtl/dac_upd_ctl.sv
module dac_upd_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ldac_ni,
  input  logic level_mode_i,
  output logic upd_o
);
  logic ldac_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ldac_q <= 1'b1;
    else         ldac_q <= ldac_ni;
  end

  assign upd_o = level_mode_i ? ~ldac_ni : (~ldac_ni & ldac_q);

  // R7
  edge_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_o && !level_mode_i) |=> (!upd_o || level_mode_i));
endmodule

// File: rtl/dac_latch.sv
module dac_latch #(
  parameter int unsigned CODE_W = 14,
  parameter logic [CODE_W-1:0] CLR_CODE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              upd_i,
  input  logic [CODE_W-1:0] d_i,
  output logic [CODE_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni or negedge clr_ni) begin
    if (!rst_ni || !clr_ni) q_o <= CLR_CODE;
    else if (upd_i)         q_o <= d_i;
  end

  // R10
  clr_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> q_o == CLR_CODE);
  // R9
  no_upd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    !upd_i |=> $stable(q_o));
  // R12
  upd_takes_old_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    upd_i |=> q_o == $past(d_i));
endmodule

// File: rtl/dac_byte_loader.sv
module dac_byte_loader
  import dac_ldr_pkg::*;
#(
  parameter int unsigned N_CH   = NUM_CH,
  parameter int unsigned DW     = CODE_W,
  parameter int unsigned BYTE_W = LO_W,
  parameter int unsigned AW     = ADDR_W,
  parameter logic [DW-1:0] CLR_CODE = CLR_DEFAULT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               wr_ni,
  input  logic               byte_hi_i,
  input  logic               word_mode_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      data_i,
  input  logic               ldac_ni,
  input  logic               ldac_level_i,
  input  logic               clr_ni,
  output logic [N_CH*DW-1:0] dac_code_o
);
  logic [N_CH-1:0] we_lo;
  logic [N_CH-1:0] we_hi;
  logic [DW-1:0]   wdata;
  logic            upd;

  dac_wr_steer #(.NUM_CH(N_CH), .CODE_W(DW), .LO_W(BYTE_W), .ADDR_W(AW)) i_steer (
    .clk_i, .rst_ni, .cs_ni, .wr_ni, .byte_hi_i, .word_mode_i, .addr_i, .data_i,
    .we_lo_o(we_lo), .we_hi_o(we_hi), .wdata_o(wdata)
  );

  dac_upd_ctl i_upd (
    .clk_i, .rst_ni, .ldac_ni, .level_mode_i(ldac_level_i), .upd_o(upd)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [DW-1:0] in_q;
    dac_in_reg #(.CODE_W(DW), .LO_W(BYTE_W), .RST_CODE(CLR_CODE)) i_in (
      .clk_i, .rst_ni, .we_lo_i(we_lo[c]), .we_hi_i(we_hi[c]), .d_i(wdata), .q_o(in_q)
    );
    dac_latch #(.CODE_W(DW), .CLR_CODE(CLR_CODE)) i_lat (
      .clk_i, .rst_ni, .clr_ni, .upd_i(upd), .d_i(in_q), .q_o(dac_code_o[c*DW +: DW])
    );
  end

  // R11
  clr_blocks_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_ni && upd) |=> (!clr_ni || $past(!clr_ni)) |-> dac_code_o == {N_CH{CLR_CODE}});
endmodule

// File: tb/test_dac_byte_loader.sv
module test_dac_byte_loader;
  localparam int NCH = 4;
  localparam int DW  = 14;
  localparam logic [DW-1:0] CLRC = 14'h2000;

  logic clk_i = 0, rst_ni = 0, cs_ni = 1, wr_ni = 1, byte_hi_i = 0, word_mode_i = 0;
  logic [2:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic ldac_ni = 1, ldac_level_i = 0, clr_ni = 1;
  logic [NCH*DW-1:0] dac_code_o;

  int checks = 0, errors = 0;
  logic [DW-1:0] exp_in [NCH];
  logic [DW-1:0] exp_lat [NCH];

  dac_byte_loader i_dac_byte_loader (.*);

  always #2 clk_i = ~clk_i;

  task automatic tick();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic chk(input string req, input int ch, input logic [DW-1:0] exp);
    logic [DW-1:0] act;
    act = dac_code_o[ch*DW +: DW];
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s ch%0d actual=%h expected=%h", req, ch, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int c = 0; c < NCH; c++) chk(req, c, exp_lat[c]);
  endtask

  task automatic wr_cycle(input logic cs, input logic [2:0] a, input logic [DW-1:0] d,
                          input logic hi, input logic word);
    cs_ni = cs; wr_ni = 0; addr_i = a; data_i = d; byte_hi_i = hi; word_mode_i = word;
    tick();
    wr_ni = 1;
    tick();
    cs_ni = 1;
    if (!cs && a < NCH) begin
      if (word) exp_in[a] = d;
      else if (hi) exp_in[a][13:8] = d[5:0];
      else exp_in[a][7:0] = d[7:0];
    end
  endtask

  task automatic ldac_pulse();
    ldac_ni = 0; tick(); ldac_ni = 1; tick();
    for (int c = 0; c < NCH; c++) exp_lat[c] = exp_in[c];
  endtask

  task automatic t_reset();
    chk_all("R1 reset latch");
    ldac_pulse();
    chk_all("R1 reset input regs");
  endtask

  task automatic t_word();
    wr_cycle(0, 3'd0, 14'h1234, 0, 1);
    wr_cycle(0, 3'd3, 14'h3abc, 1, 1);   // R5 byte select ignored
    chk_all("R9 write alone");
    ldac_pulse();
    chk_all("R5 R7 word load");
  endtask

  task automatic t_bytes();
    wr_cycle(0, 3'd1, 14'h00a5, 0, 0);
    wr_cycle(0, 3'd1, 14'h3fff, 1, 0);
    wr_cycle(0, 3'd2, 14'h3f5c, 0, 0);
    ldac_pulse();
    chk(  "R3 R4 byte pair", 1, 14'h3fa5);
    chk(  "R3 hi kept", 2, 14'h205c);
    wr_cycle(0, 3'd2, 14'h0011, 1, 0);
    ldac_pulse();
    chk(  "R4 lo kept", 2, 14'h115c);
  endtask

  task automatic t_cs_addr();
    wr_cycle(1, 3'd2, 14'h0777, 0, 1);
    ldac_pulse();
    chk("R2 cs high", 2, 14'h115c);
    for (int a = 4; a < 8; a++) wr_cycle(0, 3'(a), 14'h0555, 0, 1);
    ldac_pulse();
    chk_all("R6 high address");
  endtask

  task automatic t_edge_hold();
    ldac_ni = 0; tick();
    for (int c = 0; c < NCH; c++) exp_lat[c] = exp_in[c];
    wr_cycle(0, 3'd0, 14'h0aaa, 0, 1);
    tick(); tick();
    chk("R7 held low no reload", 0, exp_lat[0]);
    ldac_ni = 1; tick();
    ldac_pulse();
    chk("R7 next edge", 0, 14'h0aaa);
  endtask

  task automatic t_level();
    logic [DW-1:0] old;
    ldac_level_i = 1; ldac_ni = 0; tick();
    old = exp_in[2];
    wr_cycle(0, 3'd2, 14'h2468, 0, 1);
    chk("R8 one-cycle lag", 2, old);
    tick();
    chk("R8 follows", 2, 14'h2468);
    ldac_ni = 1; ldac_level_i = 0; tick();
    for (int c = 0; c < NCH; c++) exp_lat[c] = exp_in[c];
  endtask

  task automatic t_clear();
    clr_ni = 0; #1;
    for (int c = 0; c < NCH; c++) chk("R10 async clear", c, CLRC);
    @(negedge clk_i);
    ldac_ni = 0; tick(); ldac_ni = 1; tick();
    for (int c = 0; c < NCH; c++) chk("R11 clear over load", c, CLRC);
    clr_ni = 1; tick();
    for (int c = 0; c < NCH; c++) exp_lat[c] = CLRC;
    ldac_pulse();
    chk_all("R10 input regs kept");
  endtask

  task automatic t_collide();
    logic [DW-1:0] old;
    old = exp_in[1];
    cs_ni = 0; wr_ni = 0; addr_i = 3'd1; data_i = 14'h0f0f; word_mode_i = 1;
    tick();
    wr_ni = 1; ldac_ni = 0;
    tick();
    cs_ni = 1; ldac_ni = 1;
    exp_in[1] = 14'h0f0f;
    chk("R12 same-cycle old value", 1, old);
    tick();
    ldac_pulse();
    chk("R12 next load new", 1, 14'h0f0f);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin exp_in[c] = CLRC; exp_lat[c] = CLRC; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    tick();
    t_reset();
    t_word();
    t_bytes();
    t_cs_addr();
    t_edge_hold();
    t_level();
    t_clear();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule